// File: doc/BRIEF.md
# Always-On Timer with Compare Alarms and Count Snapshots

The block keeps a free-running 48-bit count that advances by one on every clock and wraps to zero after its all-ones value. Software reaches it through a 32-bit register window of 1 KB. Two compare targets can each raise a one-shot wake-up alarm. Each target is programmed as a 32-bit low word and a 16-bit high word, and has its own enable bit that clears itself when the alarm fires.

The live count cannot be read directly. Software takes a snapshot into a read-only buffer instead, either by writing a trigger bit or by selecting one or more hardware event pulses that take the snapshot without software action. Every snapshot pushes the older buffer contents one slot down, so the last two captures can be read.

Two interrupt groups observe the same events: one for the main processor and one for a low-power coprocessor. Each group has its own raw, status, enable and clear registers and drives its own level interrupt line. A read/write identification word sits at the top of the window.

Top module: `rtc_alarm_timer`

## Requirements
- R1: After reset every register reads zero except the identification word at 0x3FC, which reads 36769936 with bit 31 clear. Both interrupt outputs are low.
- R2: The count rises by exactly one per clock, starting from the START parameter (default zero).
- R3: Targets 0 and 1 sit at 0x00/0x04 and 0x08/0x0C. The low word holds count bits 31:0, and the high word holds count bits 47:32 in its bits 15:0 and the enable in bit 31. Bits 30:16 of the high word read zero.
- R4: When an enabled target's value is at or below the count, both groups' raw wake bit (bit 31) is set on the next clock edge and that target's enable reads back zero.
- R5: A target whose enable is zero never sets the wake bit, whatever its value.
- R6: Writing 1 to bit 27 at 0x10 copies the count into buffer 0 (0x14 low word, 0x18 bits 15:0 high word). The old buffer 0 moves to buffer 1 (0x1C/0x20). Bit 27 always reads zero.
- R7: Bits 28 to 31 at 0x10 are read/write selects for the register-DMA-active, crystal-power-up, CPU-stall-change and core-reset-done event pulses, in that order. A pulse on a selected event takes a snapshot, and a pulse on an unselected event is ignored.
- R8: A software trigger and a selected event in the same cycle take exactly one snapshot.
- R9: When the count wraps from all-ones to zero, the overflow raw bit (bit 30) is set in both groups.
- R10: Each group's status register equals raw AND enable, and its interrupt output is high whenever any status bit is set. The main processor's group is raw 0x28, status 0x2C, enable 0x30. The coprocessor's group is the same layout at 0x38, 0x3C and 0x40.
- R11: Writing 1s to a group's clear register (0x34 or 0x44) clears those raw bits in that group only. If an event sets a raw bit in the same cycle that it is cleared, the bit is set.
- R12: The identification word is read/write on all 32 bits. Unmapped offsets read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 10 | Byte offset in the window, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ev_regdma | input | 1 | Register-DMA-active event pulse |
| ev_xtal_up | input | 1 | Crystal clock power-up event pulse |
| ev_cpu_stall | input | 1 | CPU stall entry or exit event pulse |
| ev_core_rst | input | 1 | Core reset completion event pulse |
| irq_cpu | output | 1 | Level interrupt to the main processor |
| irq_copro | output | 1 | Level interrupt to the coprocessor |

## Verification
The alarm path is exercised in three ways. A disabled target at zero shows that the enable gates firing. An enabled target ahead of the count shows the at-or-above compare and the one-shot clear. A clear written in the exact firing cycle shows the set-over-clear priority. Snapshots are taken by software alone, by each selected and unselected event, and by software and an event together, which separates a correct single shift from a double shift or a lost trigger. The count starts just below all-ones, so the wrap and the overflow bit are reached in both groups, and the groups are cleared and masked separately to show they are independent.

// File: rtl/rtc_tmr_pkg.sv
package rtc_tmr_pkg;
  localparam int ADDR_W   = 10;
  localparam int DATA_W   = 32;
  localparam int NUM_TGT  = 2;
  localparam int NUM_GRP  = 2;
  localparam int NUM_EVT  = 4;

  // register offsets
  localparam logic [ADDR_W-1:0] OFS_TGT_BASE = 10'h000; // stride 8: low, high
  localparam logic [ADDR_W-1:0] OFS_SNAPCTL  = 10'h010;
  localparam logic [ADDR_W-1:0] OFS_BUF0_LO  = 10'h014;
  localparam logic [ADDR_W-1:0] OFS_BUF0_HI  = 10'h018;
  localparam logic [ADDR_W-1:0] OFS_BUF1_LO  = 10'h01C;
  localparam logic [ADDR_W-1:0] OFS_BUF1_HI  = 10'h020;
  localparam logic [ADDR_W-1:0] OFS_GRP_BASE = 10'h028; // stride 16: raw, stat, ena, clr
  localparam logic [ADDR_W-1:0] OFS_IDENT    = 10'h3FC;

  localparam int BIT_SNAP_SW = 27;
  localparam int BIT_SEL_LSB = 28;
  localparam int BIT_TGT_EN  = 31;

  // raw/status/enable pair: [1] = wake (bit 31), [0] = overflow (bit 30)
  typedef logic [1:0] irq_pair_t;

  function automatic logic alarm_due(input logic en, input logic [63:0] cnt,
                                     input logic [63:0] tgt);
    return en && (cnt >= tgt);
  endfunction

  function automatic logic snap_due(input logic sw, input logic [NUM_EVT-1:0] sel,
                                    input logic [NUM_EVT-1:0] evt);
    return sw || (|(sel & evt));
  endfunction

  function automatic irq_pair_t raw_next(input irq_pair_t raw, input irq_pair_t set,
                                         input irq_pair_t clr);
    return (raw & ~clr) | set;
  endfunction

  function automatic logic [ADDR_W-1:0] tgt_ofs(input int idx, input int word);
    return OFS_TGT_BASE + ADDR_W'(idx * 8 + word * 4);
  endfunction

  function automatic logic [ADDR_W-1:0] grp_ofs(input int idx, input int word);
    return OFS_GRP_BASE + ADDR_W'(idx * 16 + word * 4);
  endfunction
endpackage

// File: rtl/rtc_tmr_counter.sv
module rtc_tmr_counter #(
  parameter int CNT_W = 48,
  parameter logic [CNT_W-1:0] START = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic             at_max
);
  assign at_max = (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= START;
    else        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rtc_tmr_alarm.sv
module rtc_tmr_alarm
  import rtc_tmr_pkg::*;
#(
  parameter int CNT_W = 48,
  localparam int HI_W = CNT_W - 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [31:0]      lo_data,
  input  logic [HI_W-1:0]  hi_data,
  input  logic             en_data,
  output logic [CNT_W-1:0] tgt,
  output logic             en,
  output logic             fire
);
  assign fire = alarm_due(en, 64'(cnt), 64'(tgt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt <= '0;
      en  <= 1'b0;
    end else begin
      if (wr_lo) tgt[31:0] <= lo_data;
      if (wr_hi) begin
        tgt[CNT_W-1:32] <= hi_data;
        en              <= en_data;
      end else if (fire) begin
        en <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rtc_tmr_snap.sv
module rtc_tmr_snap
  import rtc_tmr_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   cnt,
  input  logic               sw_req,
  input  logic [NUM_EVT-1:0] sel,
  input  logic [NUM_EVT-1:0] evt,
  output logic               take,
  output logic [CNT_W-1:0]   buf0,
  output logic [CNT_W-1:0]   buf1
);
  assign take = snap_due(sw_req, sel, evt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf0 <= '0;
      buf1 <= '0;
    end else if (take) begin
      buf1 <= buf0;
      buf0 <= cnt;
    end
  end
endmodule

// File: rtl/rtc_tmr_irq_grp.sv
module rtc_tmr_irq_grp
  import rtc_tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  irq_pair_t set,
  input  logic      wr_ena,
  input  logic      wr_clr,
  input  irq_pair_t wdata,
  output irq_pair_t raw,
  output irq_pair_t ena,
  output irq_pair_t status,
  output logic      irq
);
  irq_pair_t clr;

  assign clr    = wr_clr ? wdata : 2'b00;
  assign status = raw & ena;
  assign irq    = |status;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw <= '0;
      ena <= '0;
    end else begin
      raw <= raw_next(raw, set, clr);
      if (wr_ena) ena <= wdata;
    end
  end
endmodule

// File: rtl/rtc_alarm_timer.sv
module rtc_alarm_timer
  import rtc_tmr_pkg::*;
#(
  parameter int CNT_W = 48,
  parameter logic [CNT_W-1:0] START = '0,
  parameter logic [30:0] IDENT_RST = 31'd36769936
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ev_regdma,
  input  logic              ev_xtal_up,
  input  logic              ev_cpu_stall,
  input  logic              ev_core_rst,
  output logic              irq_cpu,
  output logic              irq_copro
);
  localparam int HI_W = CNT_W - 32;
  localparam int PAD  = 31 - HI_W;

  // visible internal events
  logic [CNT_W-1:0]   cnt;
  logic               at_max;
  logic [NUM_TGT-1:0] tgt_en;
  logic [NUM_TGT-1:0] tgt_fire;
  logic [NUM_TGT-1:0] tgt_hi_wr;
  logic [CNT_W-1:0]   tgt_val [NUM_TGT];
  logic               snap_take;
  logic [CNT_W-1:0]   buf0, buf1;
  logic [NUM_EVT-1:0] snap_sel;
  logic [NUM_EVT-1:0] evt_vec;
  logic               snap_sw;
  irq_pair_t          irq_set;
  logic [NUM_GRP-1:0][1:0] grp_raw, grp_ena, grp_stat;
  logic [NUM_GRP-1:0] grp_irq;
  logic [31:0]        ident;

  assign evt_vec = {ev_core_rst, ev_cpu_stall, ev_xtal_up, ev_regdma};

  rtc_tmr_counter #(.CNT_W(CNT_W), .START(START)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .at_max(at_max)
  );

  for (genvar i = 0; i < NUM_TGT; i++) begin : g_tgt
    logic wr_lo;
    assign wr_lo        = bus_wr && (bus_addr == tgt_ofs(i, 0));
    assign tgt_hi_wr[i] = bus_wr && (bus_addr == tgt_ofs(i, 1));
    rtc_tmr_alarm #(.CNT_W(CNT_W)) u_alarm (
      .clk(clk), .rst_n(rst_n), .cnt(cnt),
      .wr_lo(wr_lo), .wr_hi(tgt_hi_wr[i]),
      .lo_data(bus_wdata), .hi_data(bus_wdata[HI_W-1:0]),
      .en_data(bus_wdata[BIT_TGT_EN]),
      .tgt(tgt_val[i]), .en(tgt_en[i]), .fire(tgt_fire[i])
    );
  end

  // snapshot control
  logic snapctl_wr;
  assign snapctl_wr = bus_wr && (bus_addr == OFS_SNAPCTL);
  assign snap_sw    = snapctl_wr && bus_wdata[BIT_SNAP_SW];

  always_ff @(posedge clk) begin
    if (!rst_n)          snap_sel <= '0;
    else if (snapctl_wr) snap_sel <= bus_wdata[BIT_SEL_LSB +: NUM_EVT];
  end

  rtc_tmr_snap #(.CNT_W(CNT_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .sw_req(snap_sw),
    .sel(snap_sel), .evt(evt_vec), .take(snap_take), .buf0(buf0), .buf1(buf1)
  );

  // interrupt groups share one set vector
  assign irq_set = {|tgt_fire, at_max};

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic wr_ena, wr_clr;
    assign wr_ena = bus_wr && (bus_addr == grp_ofs(g, 2));
    assign wr_clr = bus_wr && (bus_addr == grp_ofs(g, 3));
    rtc_tmr_irq_grp u_grp (
      .clk(clk), .rst_n(rst_n), .set(irq_set),
      .wr_ena(wr_ena), .wr_clr(wr_clr), .wdata(bus_wdata[31:30]),
      .raw(grp_raw[g]), .ena(grp_ena[g]), .status(grp_stat[g]), .irq(grp_irq[g])
    );
  end

  assign irq_cpu   = grp_irq[0];
  assign irq_copro = grp_irq[1];

  always_ff @(posedge clk) begin
    if (!rst_n)                                  ident <= {1'b0, IDENT_RST};
    else if (bus_wr && bus_addr == OFS_IDENT)    ident <= bus_wdata;
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_TGT; i++) begin
      if (bus_addr == tgt_ofs(i, 0)) bus_rdata = tgt_val[i][31:0];
      if (bus_addr == tgt_ofs(i, 1))
        bus_rdata = {tgt_en[i], {PAD{1'b0}}, tgt_val[i][CNT_W-1:32]};
    end
    for (int g = 0; g < NUM_GRP; g++) begin
      if (bus_addr == grp_ofs(g, 0)) bus_rdata = {grp_raw[g],  30'b0};
      if (bus_addr == grp_ofs(g, 1)) bus_rdata = {grp_stat[g], 30'b0};
      if (bus_addr == grp_ofs(g, 2)) bus_rdata = {grp_ena[g],  30'b0};
    end
    case (bus_addr)
      OFS_SNAPCTL: bus_rdata = {snap_sel, {BIT_SEL_LSB{1'b0}}};
      OFS_BUF0_LO: bus_rdata = buf0[31:0];
      OFS_BUF0_HI: bus_rdata = {{(32-HI_W){1'b0}}, buf0[CNT_W-1:32]};
      OFS_BUF1_LO: bus_rdata = buf1[31:0];
      OFS_BUF1_HI: bus_rdata = {{(32-HI_W){1'b0}}, buf1[CNT_W-1:32]};
      OFS_IDENT:   bus_rdata = ident;
      default: ;
    endcase
  end
endmodule

// File: rtl/rtc_tmr_chk.sv
module rtc_tmr_chk #(
  parameter int CNT_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic             at_max,
  input logic [1:0]       tgt_fire,
  input logic [1:0]       tgt_en,
  input logic [1:0]       tgt_hi_wr,
  input logic             snap_take,
  input logic [CNT_W-1:0] buf0,
  input logic [CNT_W-1:0] buf1,
  input logic [1:0]       raw_cpu,
  input logic [1:0]       raw_cop,
  input logic [1:0]       ena_cpu,
  input logic [1:0]       ena_cop,
  input logic             irq_cpu,
  input logic             irq_copro
);
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !at_max |=> cnt == $past(cnt) + 1'b1);

  a_r9_wrap_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    at_max |=> (cnt == '0) && raw_cpu[0] && raw_cop[0]);

  a_r4_fire_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (|tgt_fire) |=> raw_cpu[1] && raw_cop[1]);

  a_r4_one_shot0: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_fire[0] && !tgt_hi_wr[0]) |=> !tgt_en[0]);

  a_r4_one_shot1: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_fire[1] && !tgt_hi_wr[1]) |=> !tgt_en[1]);

  a_r6_shift: assert property (@(posedge clk) disable iff (!rst_n)
    snap_take |=> (buf1 == $past(buf0)) && (buf0 == $past(cnt)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_take |=> $stable(buf0) && $stable(buf1));

  a_r10_irq_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cpu == (|(raw_cpu & ena_cpu)));

  a_r10_irq_cop: assert property (@(posedge clk) disable iff (!rst_n)
    irq_copro == (|(raw_cop & ena_cop)));
endmodule

bind rtc_alarm_timer rtc_tmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .at_max(at_max),
  .tgt_fire(tgt_fire), .tgt_en(tgt_en), .tgt_hi_wr(tgt_hi_wr),
  .snap_take(snap_take), .buf0(buf0), .buf1(buf1),
  .raw_cpu(grp_raw[0]), .raw_cop(grp_raw[1]),
  .ena_cpu(grp_ena[0]), .ena_cop(grp_ena[1]),
  .irq_cpu(irq_cpu), .irq_copro(irq_copro)
);

// File: tb/rtc_alarm_timer_tb.sv
module rtc_alarm_timer_tb_top;
  localparam logic [47:0] START = 48'hFFFF_FFFF_F000;
  localparam logic [47:0] MAXV  = 48'hFFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  evt = '0;
  logic        irq_cpu, irq_copro;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtc_alarm_timer #(.START(START)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_regdma(evt[0]), .ev_xtal_up(evt[1]), .ev_cpu_stall(evt[2]),
    .ev_core_rst(evt[3]), .irq_cpu(irq_cpu), .irq_copro(irq_copro)
  );

  // ---------------- behavioural reference model ----------------
  logic [47:0] m_cnt, m_buf0, m_buf1;
  logic [47:0] m_tgt [2];
  bit   [1:0]  m_en;
  bit   [3:0]  m_sel;
  bit   [1:0]  m_raw [2];
  bit   [1:0]  m_ena [2];
  logic [31:0] m_ident;

  always @(posedge clk) begin
    bit [1:0] setv;
    bit [1:0] clr [2];
    bit [1:0] fired;
    if (!rst_n) begin
      m_cnt = START; m_buf0 = 0; m_buf1 = 0; m_en = 0; m_sel = 0;
      m_tgt[0] = 0; m_tgt[1] = 0;
      m_raw[0] = 0; m_raw[1] = 0; m_ena[0] = 0; m_ena[1] = 0;
      m_ident = 32'd36769936;
    end else begin
      clr[0] = 0; clr[1] = 0;
      fired[0] = m_en[0] && (m_cnt >= m_tgt[0]);
      fired[1] = m_en[1] && (m_cnt >= m_tgt[1]);
      setv = {fired != 0, m_cnt == MAXV};
      if ((bus_wr && bus_addr == 10'h010 && bus_wdata[27]) || ((m_sel & evt) != 0)) begin
        m_buf1 = m_buf0;
        m_buf0 = m_cnt;
      end
      m_cnt = m_cnt + 1;
      if (fired[0]) m_en[0] = 0;
      if (fired[1]) m_en[1] = 0;
      if (bus_wr) begin
        case (bus_addr)
          10'h000: m_tgt[0][31:0] = bus_wdata;
          10'h004: begin m_tgt[0][47:32] = bus_wdata[15:0]; m_en[0] = bus_wdata[31]; end
          10'h008: m_tgt[1][31:0] = bus_wdata;
          10'h00C: begin m_tgt[1][47:32] = bus_wdata[15:0]; m_en[1] = bus_wdata[31]; end
          10'h010: m_sel = bus_wdata[31:28];
          10'h030: m_ena[0] = bus_wdata[31:30];
          10'h034: clr[0] = bus_wdata[31:30];
          10'h040: m_ena[1] = bus_wdata[31:30];
          10'h044: clr[1] = bus_wdata[31:30];
          10'h3FC: m_ident = bus_wdata;
          default: ;
        endcase
      end
      for (int g = 0; g < 2; g++) m_raw[g] = (m_raw[g] & ~clr[g]) | setv;
    end
  end

  function automatic logic [31:0] mread(input logic [9:0] a);
    case (a)
      10'h000: return m_tgt[0][31:0];
      10'h004: return {m_en[0], 15'b0, m_tgt[0][47:32]};
      10'h008: return m_tgt[1][31:0];
      10'h00C: return {m_en[1], 15'b0, m_tgt[1][47:32]};
      10'h010: return {m_sel, 28'b0};
      10'h014: return m_buf0[31:0];
      10'h018: return {16'b0, m_buf0[47:32]};
      10'h01C: return m_buf1[31:0];
      10'h020: return {16'b0, m_buf1[47:32]};
      10'h028: return {m_raw[0], 30'b0};
      10'h02C: return {m_raw[0] & m_ena[0], 30'b0};
      10'h030: return {m_ena[0], 30'b0};
      10'h038: return {m_raw[1], 30'b0};
      10'h03C: return {m_raw[1] & m_ena[1], 30'b0};
      10'h040: return {m_ena[1], 30'b0};
      10'h3FC: return m_ident;
      default: return 32'h0;
    endcase
  endfunction

  // per-clock comparison of the interrupt lines (R10)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      tests++;
      if ({irq_cpu, irq_copro} != {(m_raw[0] & m_ena[0]) != 0, (m_raw[1] & m_ena[1]) != 0}) begin
        fails++;
        $display("FAIL R10 irq lines at %0t: actual %b expected %b", $time,
                 {irq_cpu, irq_copro},
                 {(m_raw[0] & m_ena[0]) != 0, (m_raw[1] & m_ena[1]) != 0});
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic chk_model(input logic [9:0] a, input string req);
    logic [31:0] d;
    rd(a, d);
    check32(req, d, mread(a));
  endtask

  task automatic chk_lit(input logic [9:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    rd(a, d);
    check32(req, d, exp);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    evt[idx] = 1'b1;
    @(negedge clk);
    evt = '0;
  endtask

  initial begin
    #(10 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] b0lo, b0lo_prev, d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    for (int a = 0; a <= 10'h044; a += 4)
      chk_lit(10'(a), 32'h0, "R1 reset register");
    chk_lit(10'h3FC, 32'd36769936, "R1 identification reset");
    check32("R1 irq lines", {30'b0, irq_cpu, irq_copro}, 32'h0);

    // R12: identification R/W, unmapped offsets
    wr(10'h3FC, 32'h8000_1234);
    chk_lit(10'h3FC, 32'h8000_1234, "R12 ident write");
    wr(10'h200, 32'hFFFF_FFFF);
    chk_lit(10'h200, 32'h0, "R12 unmapped read");
    chk_lit(10'h048, 32'h0, "R12 unmapped read 0x48");

    // R3: target field layout
    wr(10'h000, 32'hDEAD_BEEF);
    wr(10'h004, 32'h7FFF_ABCD);
    chk_lit(10'h000, 32'hDEAD_BEEF, "R3 target low");
    chk_lit(10'h004, 32'h0000_ABCD, "R3 target high reserved zero");

    // R6: software snapshot and shift
    wr(10'h010, 32'h0800_0000);
    chk_model(10'h014, "R6 buf0 low");
    chk_lit(10'h018, 32'h0000_FFFF, "R6 buf0 high");
    chk_lit(10'h010, 32'h0, "R6 trigger bit reads zero");
    rd(10'h014, b0lo);
    check32("R2 snapshot near start", {31'b0, (b0lo > 32'hFFFF_F000) && (b0lo < 32'hFFFF_F100)}, 32'h1);
    wr(10'h010, 32'h0800_0000);
    chk_lit(10'h01C, b0lo, "R6 old buf0 moved to buf1");
    rd(10'h014, d);
    check32("R2 count advanced by write spacing", d - b0lo, 32'd2);

    // R7: selected and unselected events (select regdma and cpu stall)
    wr(10'h010, 32'h5000_0000);
    chk_lit(10'h010, 32'h5000_0000, "R7 select readback");
    rd(10'h014, b0lo);
    pulse(1);
    chk_lit(10'h014, b0lo, "R7 unselected xtal event ignored");
    pulse(3);
    chk_lit(10'h014, b0lo, "R7 unselected core-reset event ignored");
    pulse(0);
    chk_model(10'h014, "R7 regdma event snapshot");
    chk_lit(10'h01C, b0lo, "R7 regdma shifts buffer");
    rd(10'h014, b0lo);
    pulse(2);
    chk_model(10'h014, "R7 stall event snapshot");
    chk_lit(10'h01C, b0lo, "R7 stall shifts buffer");

    // R8: software and event together, single shift
    rd(10'h014, b0lo_prev);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 10'h010; bus_wdata = 32'h5800_0000; evt[0] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; evt = '0;
    chk_lit(10'h01C, b0lo_prev, "R8 single snapshot on coincident triggers");
    chk_model(10'h014, "R8 buf0 after coincident triggers");

    // R5: disabled target at zero never fires
    wr(10'h000, 32'h0);
    wr(10'h004, 32'h0);
    repeat (10) @(negedge clk);
    chk_lit(10'h028, 32'h0, "R5 disabled target no wake");

    // R4: enabled target ahead of the count
    wr(10'h030, 32'h8000_0000);
    wr(10'h040, 32'h8000_0000);
    wr(10'h008, 32'hFFFF_F3E8);
    wr(10'h00C, 32'h8000_FFFF);
    chk_lit(10'h00C, 32'h8000_FFFF, "R3 enable readback");
    chk_lit(10'h028, 32'h0, "R4 not yet reached");
    for (int k = 0; k < 2000 && !irq_cpu; k++) @(negedge clk);
    chk_lit(10'h028, 32'h8000_0000, "R4 cpu wake raw");
    chk_lit(10'h038, 32'h8000_0000, "R4 coprocessor wake raw");
    chk_lit(10'h00C, 32'h0000_FFFF, "R4 enable self-cleared");
    check32("R4 count at firing", {31'b0, m_cnt >= 48'hFFFF_FFFF_F3E8}, 32'h1);

    // R11: clear only the cpu group
    wr(10'h034, 32'hC000_0000);
    chk_lit(10'h028, 32'h0, "R11 cpu raw cleared");
    chk_lit(10'h038, 32'h8000_0000, "R11 coprocessor raw untouched");

    // R10: masking in coprocessor group
    wr(10'h040, 32'h0);
    chk_lit(10'h03C, 32'h0, "R10 status masked");
    check32("R10 irq_copro low when masked", {31'b0, irq_copro}, 32'h0);
    wr(10'h040, 32'h8000_0000);
    chk_lit(10'h03C, 32'h8000_0000, "R10 status unmasked");
    check32("R10 irq_copro high", {31'b0, irq_copro}, 32'h1);

    // R9: wrap sets overflow in both groups
    wr(10'h030, 32'h4000_0000);
    while (!(m_cnt < 48'd10)) @(negedge clk);
    chk_lit(10'h028, 32'h4000_0000, "R9 cpu overflow raw");
    chk_lit(10'h038, 32'hC000_0000, "R9 coprocessor overflow raw");
    check32("R9 irq_cpu on overflow", {31'b0, irq_cpu}, 32'h1);
    wr(10'h010, 32'h0800_0000);
    chk_lit(10'h018, 32'h0, "R2 count wrapped high word");
    chk_model(10'h014, "R2 count after wrap");

    // R11: set wins over clear in the same cycle
    wr(10'h034, 32'hC000_0000);
    wr(10'h000, 32'd200);
    wr(10'h004, 32'h8000_0000);
    while (m_cnt != 48'd200) @(negedge clk);
    bus_wr = 1'b1; bus_addr = 10'h034; bus_wdata = 32'h8000_0000;
    @(negedge clk);
    bus_wr = 1'b0;
    chk_lit(10'h028, 32'h8000_0000, "R11 set wins over clear");
    chk_lit(10'h004, 32'h0, "R4 target0 enable self-cleared");

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule